// File: doc/BRIEF.md
# Host-to-DSP Mailbox with Reply Flag

This block passes 16-bit words between a host bus and a signal processor through two one-word latches. A host write fills the inbound latch and raises a level interrupt request toward the DSP. The DSP takes the word by reading its I/O port, and that read drops the request. The DSP answers by writing the same I/O port, which fills the outbound latch and pulls an active-low reply flag to 0. The host then reads the outbound latch, and that read sets the flag back to 1.

The DSP can poll the flag by reading slot 5 of a small memory-mapped control register file. Every other slot of that file is plain storage. All strobes are single-cycle. All read data is registered and appears on the clock edge after the strobe. Each read-data output keeps its value until the next read on its own side.

Top module: `mbx_host_dsp`

## Requirements
- R1: During and after a synchronous reset, reply_pend_n is 1, dsp_irq is 0, both latches hold 0, and every read-data output is 0.
- R2: A host_wr stores host_wdata in the inbound latch and makes dsp_irq 1 from the next edge. A second host_wr before the DSP reads replaces the word, and dsp_irq stays 1.
- R3: A dsp_io_rd with dsp_io_addr equal to 3 puts the inbound latch on dsp_io_rdata at the next edge and clears dsp_irq. If host_wr happens in the same cycle, dsp_irq stays 1 and the read returns the word held before that cycle.
- R4: A dsp_io_wr with dsp_io_addr equal to 3 stores dsp_io_wdata in the outbound latch and drives reply_pend_n to 0 at the next edge.
- R5: A host_rd puts the outbound latch on host_rdata at the next edge and sets reply_pend_n to 1.
- R6: When an outbound DSP write and a host_rd fall in the same cycle, reply_pend_n becomes 0, and host_rdata returns the outbound word held before that cycle.
- R7: A DSP I/O access at any address other than 3 is ignored. A read there returns 0 on dsp_io_rdata and leaves dsp_irq unchanged. A write there changes neither the outbound latch nor reply_pend_n.
- R8: A dsp_ctl_rd at offset 5 returns reply_pend_n in bit 0 and zeros in bits 15:1, whatever was written to that offset.
- R9: A dsp_ctl_wr stores 16 bits at any offset. A later read at any offset other than 5 returns the stored word. A write to offset 5 leaves reply_pend_n unchanged. A read and a write to the same slot in the same cycle return the old contents.
- R10: host_rdata, dsp_io_rdata and dsp_ctl_rdata change only on the edge that follows a read strobe on their own side.
- R11: Reset clears every control register slot to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the inbound latch |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe for the outbound latch |
| host_rdata | output | 16 | Registered host read data |
| dsp_io_rd | input | 1 | DSP I/O read strobe |
| dsp_io_wr | input | 1 | DSP I/O write strobe |
| dsp_io_addr | input | 16 | DSP I/O address; the mailbox sits at 3 |
| dsp_io_wdata | input | 16 | DSP I/O write data |
| dsp_io_rdata | output | 16 | Registered DSP I/O read data |
| dsp_ctl_rd | input | 1 | Control register read strobe |
| dsp_ctl_wr | input | 1 | Control register write strobe |
| dsp_ctl_addr | input | 5 | Control register offset |
| dsp_ctl_wdata | input | 16 | Control register write data |
| dsp_ctl_rdata | output | 16 | Registered control register read data |
| dsp_irq | output | 1 | Level interrupt request to the DSP |
| reply_pend_n | output | 1 | Reply flag, 0 while an unread reply waits |

## Verification
The bench aims at the collisions. The first is a DSP reply write in the same cycle as a host read. A design that orders the flag updates the wrong way would leave the flag at 1 and lose the reply. The second is a host write in the same cycle as a DSP read. A design that lets the read win would drop the interrupt for a word nobody has fetched yet.

The bench also checks slot 5 of the control file after a software write to it. A design that returns the stored word there would hide the real flag. It checks DSP I/O accesses at other addresses, which a sloppy decode would let touch the latches or the interrupt. Randomised mixed traffic then compares every output against the model on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW      = 16;
  localparam int unsigned MBX_IO_AW   = 16;
  localparam int unsigned MBX_CTL_AW  = 5;
  localparam int unsigned MBX_PORT    = 3;
  localparam int unsigned MBX_FLAG_OF = 5;

  // decoded DSP I/O accesses that hit the mailbox port
  typedef struct packed {
    logic in_rd;
    logic out_wr;
  } mbx_hit_t;
endpackage

// File: rtl/mbx_latch.sv
module mbx_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/mbx_io_decode.sv
module mbx_io_decode
  import mbx_pkg::*;
#(
  parameter int unsigned AW   = MBX_IO_AW,
  parameter int unsigned PORT = MBX_PORT
) (
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  output mbx_hit_t      hit
);
  localparam logic [AW-1:0] PORT_A = AW'(PORT);

  logic sel;
  always_comb begin
    sel        = (io_addr == PORT_A);
    hit.in_rd  = io_rd & sel;
    hit.out_wr = io_wr & sel;
  end
endmodule

// File: rtl/mbx_hs_state.sv
module mbx_hs_state (
  input  logic clk,
  input  logic rst,
  input  logic host_wr,
  input  logic host_rd,
  input  logic in_rd,
  input  logic out_wr,
  output logic irq,
  output logic flag_n
);
  // a fresh inbound word outranks the DSP fetching the previous one
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (host_wr) irq <= 1'b1;
    else if (in_rd)   irq <= 1'b0;
  end

  // a new reply outranks the host consuming the previous one
  always_ff @(posedge clk) begin
    if (rst)          flag_n <= 1'b1;
    else if (out_wr)  flag_n <= 1'b0;
    else if (host_rd) flag_n <= 1'b1;
  end
endmodule

// File: rtl/mbx_ctl_file.sv
module mbx_ctl_file
  import mbx_pkg::*;
#(
  parameter int unsigned DW      = MBX_DW,
  parameter int unsigned AW      = MBX_CTL_AW,
  parameter int unsigned FLAG_OF = MBX_FLAG_OF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          flag_n,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam logic [AW-1:0] FLAG_A = AW'(FLAG_OF);

  logic [DW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                             slot[g] <= '0;
      else if (wr && addr == AW'(g))       slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      if (addr == FLAG_A) rdata <= {{(DW-1){1'b0}}, flag_n};
      else                rdata <= slot[addr];
    end
  end
endmodule

// File: rtl/mbx_host_dsp.sv
module mbx_host_dsp
  import mbx_pkg::*;
#(
  parameter int unsigned DW      = MBX_DW,
  parameter int unsigned IO_AW   = MBX_IO_AW,
  parameter int unsigned CTL_AW  = MBX_CTL_AW,
  parameter int unsigned PORT    = MBX_PORT,
  parameter int unsigned FLAG_OF = MBX_FLAG_OF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  input  logic              dsp_io_rd,
  input  logic              dsp_io_wr,
  input  logic [IO_AW-1:0]  dsp_io_addr,
  input  logic [DW-1:0]     dsp_io_wdata,
  output logic [DW-1:0]     dsp_io_rdata,
  input  logic              dsp_ctl_rd,
  input  logic              dsp_ctl_wr,
  input  logic [CTL_AW-1:0] dsp_ctl_addr,
  input  logic [DW-1:0]     dsp_ctl_wdata,
  output logic [DW-1:0]     dsp_ctl_rdata,
  output logic              dsp_irq,
  output logic              reply_pend_n
);
  mbx_hit_t      hit;
  logic [DW-1:0] in_q;
  logic [DW-1:0] out_q;

  mbx_io_decode #(.AW(IO_AW), .PORT(PORT)) u_dec (
    .io_rd   (dsp_io_rd),
    .io_wr   (dsp_io_wr),
    .io_addr (dsp_io_addr),
    .hit     (hit)
  );

  mbx_latch #(.W(DW)) u_in (
    .clk (clk), .rst (rst), .ld (host_wr), .d (host_wdata), .q (in_q)
  );

  mbx_latch #(.W(DW)) u_out (
    .clk (clk), .rst (rst), .ld (hit.out_wr), .d (dsp_io_wdata), .q (out_q)
  );

  mbx_hs_state u_hs (
    .clk     (clk),
    .rst     (rst),
    .host_wr (host_wr),
    .host_rd (host_rd),
    .in_rd   (hit.in_rd),
    .out_wr  (hit.out_wr),
    .irq     (dsp_irq),
    .flag_n  (reply_pend_n)
  );

  mbx_ctl_file #(.DW(DW), .AW(CTL_AW), .FLAG_OF(FLAG_OF)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr     (dsp_ctl_wr),
    .rd     (dsp_ctl_rd),
    .addr   (dsp_ctl_addr),
    .wdata  (dsp_ctl_wdata),
    .flag_n (reply_pend_n),
    .rdata  (dsp_ctl_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= out_q;
  end

  always_ff @(posedge clk) begin
    if (rst)            dsp_io_rdata <= '0;
    else if (dsp_io_rd) dsp_io_rdata <= hit.in_rd ? in_q : '0;
  end
endmodule

// File: rtl/mbx_host_dsp_chk.sv
module mbx_host_dsp_chk #(
  parameter int unsigned DW      = 16,
  parameter int unsigned IO_AW   = 16,
  parameter int unsigned CTL_AW  = 5,
  parameter int unsigned PORT    = 3,
  parameter int unsigned FLAG_OF = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic              dsp_io_rd,
  input logic              dsp_io_wr,
  input logic [IO_AW-1:0]  dsp_io_addr,
  input logic              dsp_ctl_rd,
  input logic [CTL_AW-1:0] dsp_ctl_addr,
  input logic [DW-1:0]     dsp_ctl_rdata,
  input logic              dsp_irq,
  input logic              reply_pend_n
);
  logic at_port, at_flag;
  assign at_port = (dsp_io_addr == IO_AW'(PORT));
  assign at_flag = (dsp_ctl_addr == CTL_AW'(FLAG_OF));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (reply_pend_n && !dsp_irq));

  a_r2_host_wr_irq: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> dsp_irq);

  a_r3_fetch_clears: assert property (@(posedge clk) disable iff (rst)
    (dsp_io_rd && at_port && !host_wr) |=> !dsp_irq);

  a_r4_reply_flag_low: assert property (@(posedge clk) disable iff (rst)
    (dsp_io_wr && at_port) |=> !reply_pend_n);

  a_r5_host_rd_flag_high: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !(dsp_io_wr && at_port)) |=> reply_pend_n);

  a_r7_miss_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (!host_wr && !host_rd && !(dsp_io_rd && at_port) && !(dsp_io_wr && at_port))
      |=> ($stable(dsp_irq) && $stable(reply_pend_n)));

  a_r8_flag_slot: assert property (@(posedge clk) disable iff (rst)
    (dsp_ctl_rd && at_flag) |=>
      (dsp_ctl_rdata[0] == $past(reply_pend_n) && dsp_ctl_rdata[DW-1:1] == '0));
endmodule

bind mbx_host_dsp mbx_host_dsp_chk #(
  .DW(DW), .IO_AW(IO_AW), .CTL_AW(CTL_AW), .PORT(PORT), .FLAG_OF(FLAG_OF)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .dsp_io_rd     (dsp_io_rd),
  .dsp_io_wr     (dsp_io_wr),
  .dsp_io_addr   (dsp_io_addr),
  .dsp_ctl_rd    (dsp_ctl_rd),
  .dsp_ctl_addr  (dsp_ctl_addr),
  .dsp_ctl_rdata (dsp_ctl_rdata),
  .dsp_irq       (dsp_irq),
  .reply_pend_n  (reply_pend_n)
);

// File: tb/tb_mbx_host_dsp.sv
module tb_mbx_host_dsp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        dsp_io_rd = 1'b0, dsp_io_wr = 1'b0;
  logic [15:0] dsp_io_addr = '0, dsp_io_wdata = '0;
  logic        dsp_ctl_rd = 1'b0, dsp_ctl_wr = 1'b0;
  logic [4:0]  dsp_ctl_addr = '0;
  logic [15:0] dsp_ctl_wdata = '0;
  logic [15:0] host_rdata, dsp_io_rdata, dsp_ctl_rdata;
  logic        dsp_irq, reply_pend_n;

  always #4 clk = ~clk;

  mbx_host_dsp dut (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .dsp_io_rd(dsp_io_rd), .dsp_io_wr(dsp_io_wr), .dsp_io_addr(dsp_io_addr),
    .dsp_io_wdata(dsp_io_wdata), .dsp_io_rdata(dsp_io_rdata),
    .dsp_ctl_rd(dsp_ctl_rd), .dsp_ctl_wr(dsp_ctl_wr), .dsp_ctl_addr(dsp_ctl_addr),
    .dsp_ctl_wdata(dsp_ctl_wdata), .dsp_ctl_rdata(dsp_ctl_rdata),
    .dsp_irq(dsp_irq), .reply_pend_n(reply_pend_n)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_in, m_out, m_hrd, m_iord, m_crd;
  int m_irq, m_flag;
  int m_ctl [32];

  task automatic cmp(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // advance one cycle: update the model from the driven inputs, then compare
  task automatic tick(input string tag);
    bit port = (dsp_io_addr == 16'd3);
    if (rst) begin
      m_in = 0; m_out = 0; m_hrd = 0; m_iord = 0; m_crd = 0;
      m_irq = 0; m_flag = 1;
      foreach (m_ctl[i]) m_ctl[i] = 0;
    end else begin
      int n_crd = m_crd;
      if (host_rd)   m_hrd  = m_out;
      if (dsp_io_rd) m_iord = port ? m_in : 0;
      if (dsp_ctl_rd) n_crd = (dsp_ctl_addr == 5) ? m_flag : m_ctl[dsp_ctl_addr];
      if (host_wr)                m_irq = 1;
      else if (dsp_io_rd && port) m_irq = 0;
      if (dsp_io_wr && port) m_flag = 0;
      else if (host_rd)      m_flag = 1;
      if (host_wr)           m_in  = host_wdata;
      if (dsp_io_wr && port) m_out = dsp_io_wdata;
      if (dsp_ctl_wr)        m_ctl[dsp_ctl_addr] = dsp_ctl_wdata;
      m_crd = n_crd;
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "host_rdata R5",    host_rdata,    m_hrd);
    cmp(tag, "dsp_io_rdata R3",  dsp_io_rdata,  m_iord);
    cmp(tag, "dsp_ctl_rdata R9", dsp_ctl_rdata, m_crd);
    cmp(tag, "dsp_irq R2",       dsp_irq,       m_irq);
    cmp(tag, "reply_pend_n R4",  reply_pend_n,  m_flag);
    host_wr = 0; host_rd = 0; dsp_io_rd = 0; dsp_io_wr = 0;
    dsp_ctl_rd = 0; dsp_ctl_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    // R1 R11: reset state
    rst = 1; tick("R1"); tick("R1");
    rst = 0;
    dsp_ctl_rd = 1; dsp_ctl_addr = 7; tick("R11");
    dsp_ctl_rd = 1; dsp_ctl_addr = 0; tick("R11");

    // R2: two host writes before fetch
    host_wr = 1; host_wdata = 16'h1234; tick("R2");
    host_wr = 1; host_wdata = 16'hBEEF; tick("R2");
    tick("R10");
    // R3: fetch clears the request
    dsp_io_rd = 1; dsp_io_addr = 3; tick("R3");
    // R3: host write collides with fetch
    host_wr = 1; host_wdata = 16'h5A5A; tick("R2");
    host_wr = 1; host_wdata = 16'h0F0F; dsp_io_rd = 1; dsp_io_addr = 3; tick("R3");
    dsp_io_rd = 1; dsp_io_addr = 3; tick("R3");

    // R4 R8 R5: reply path with flag polling
    dsp_io_wr = 1; dsp_io_addr = 3; dsp_io_wdata = 16'hCAFE; tick("R4");
    dsp_ctl_rd = 1; dsp_ctl_addr = 5; tick("R8");
    host_rd = 1; tick("R5");
    dsp_ctl_rd = 1; dsp_ctl_addr = 5; tick("R8");

    // R6: reply write collides with host read
    dsp_io_wr = 1; dsp_io_addr = 3; dsp_io_wdata = 16'h1111; tick("R4");
    host_rd = 1; dsp_io_wr = 1; dsp_io_addr = 3; dsp_io_wdata = 16'h2222; tick("R6");
    host_rd = 1; tick("R6");

    // R7: accesses off the mailbox port
    host_wr = 1; host_wdata = 16'h7777; tick("R2");
    dsp_io_rd = 1; dsp_io_addr = 1; tick("R7");
    dsp_io_wr = 1; dsp_io_addr = 0; dsp_io_wdata = 16'hDEAD; tick("R7");
    host_rd = 1; tick("R7");
    dsp_io_rd = 1; dsp_io_addr = 16'h0103; tick("R7");

    // R9: control file storage and the flag slot
    dsp_ctl_wr = 1; dsp_ctl_addr = 0;  dsp_ctl_wdata = 16'hA001; tick("R9");
    dsp_ctl_wr = 1; dsp_ctl_addr = 31; dsp_ctl_wdata = 16'hB01F; tick("R9");
    dsp_ctl_wr = 1; dsp_ctl_addr = 5;  dsp_ctl_wdata = 16'hFFFE; tick("R9");
    dsp_ctl_rd = 1; dsp_ctl_addr = 5;  tick("R8");
    dsp_ctl_rd = 1; dsp_ctl_addr = 31; tick("R9");
    dsp_ctl_rd = 1; dsp_ctl_wr = 1; dsp_ctl_addr = 0; dsp_ctl_wdata = 16'h4444; tick("R9");
    dsp_ctl_rd = 1; dsp_ctl_addr = 0; tick("R9");
    tick("R10"); tick("R10");

    // mixed traffic across all requirements
    for (int i = 0; i < 3000; i++) begin
      host_wr       = ($urandom % 4) == 0;
      host_wdata    = 16'($urandom);
      host_rd       = ($urandom % 4) == 0;
      dsp_io_rd     = ($urandom % 3) == 0;
      dsp_io_wr     = ($urandom % 3) == 0;
      dsp_io_addr   = ($urandom % 4 == 0) ? 16'($urandom % 8) : 16'd3;
      dsp_io_wdata  = 16'($urandom);
      dsp_ctl_rd    = ($urandom % 3) == 0;
      dsp_ctl_wr    = ($urandom % 5) == 0;
      dsp_ctl_addr  = ($urandom % 3 == 0) ? 5'd5 : 5'($urandom);
      dsp_ctl_wdata = 16'($urandom);
      tick("R6");
    end

    // reset again mid-stream
    host_wr = 1; host_wdata = 16'h9999; dsp_io_wr = 1; dsp_io_addr = 3; tick("R4");
    rst = 1; tick("R1");
    rst = 0;
    dsp_ctl_rd = 1; dsp_ctl_addr = 0; tick("R11");
    summary();
  end
endmodule